// File: doc/BRIEF.md
# 4b/5b Line Encoder with NRZI Output

This block turns a stream of tagged nibbles into a serial line signal. Each nibble arrives with a tag that marks it as either a data nibble or an escape. The block maps it to one of seventeen 5-bit transmission symbols. The symbol is shifted out most significant bit first, one bit for each cycle in which the bit-clock enable is high. The resulting bit stream is then NRZI coded onto a single line output. Which nibbles are escapes, and any scrambling, are decided by logic upstream.

The upstream side uses a valid/ready handshake. The encoder takes a new nibble only in the bit slot that carries the last bit of the current symbol, so symbols follow one another with no gap. If no nibble is offered at that moment, the encoder fills the next symbol slot. A parameter selects the fill: either the escape symbol, or five zero bits, which leave the line level unchanged.

Top module: `line_enc45`

## Requirements
- R1: Each symbol occupies exactly five consecutive bit slots (cycles with `bit_en` high). Its bits are sent from bit 4 down to bit 0, and the next symbol follows in the very next bit slot.
- R2: A data nibble maps as follows. 0000→10101, 0001→01001, 0010→01010, 0011→01011, 0100→00111, 0101→01101, 0110→01110, 0111→01111, 1000→10010, 1001→11001, 1010→11010, 1011→11011, 1100→10111, 1101→11101, 1110→11110, 1111→11111.
- R3: A nibble with `in_esc` high is sent as 00010, whatever the value on `in_nib`.
- R4: The line is NRZI coded. In a bit slot, a 1 bit inverts `line_o` and a 0 bit leaves it unchanged. `line_o` only changes on a clock edge where `bit_en` is high.
- R5: `in_ready` is high only in a cycle with `bit_en` high that sends the last bit of the current symbol. The nibble is taken when `in_valid` and `in_ready` are both high.
- R6: While `bit_en` is low, `line_o` stays constant, and the symbol in progress resumes where it stopped.
- R7: Reset (`rst_n` low) drives `line_o` to 0. The first bit slot after reset carries a 0 bit and is a load slot (`in_ready` equals `bit_en`).
- R8: With `IDLE_HOLD` = 0, a load slot without `in_valid` sends the escape symbol 00010 as the next symbol.
- R9: With `IDLE_HOLD` = 1, a load slot without `in_valid` sends five 0 bits, so the line holds its level for that symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Bit-clock enable, one line bit per high cycle |
| in_valid | input | 1 | Nibble offered |
| in_ready | output | 1 | Nibble taken this cycle if valid |
| in_nib | input | 4 | Data nibble value |
| in_esc | input | 1 | Nibble is an escape, not data |
| line_o | output | 1 | NRZI-coded serial line level |

## Verification
The hardest case to reach is a load slot that coincides with a gap in `bit_en` or with a missing nibble. In that case the handshake, the fill choice and the pause in the symbol all interact. The stimulus runs the seventeen codes in rotation through several phases. One phase has `bit_en` high continuously. Another drops `bit_en` on a fixed period that is prime to the symbol length, and withdraws `in_valid` on a different period. Because of these periods, gaps and idle slots fall on every bit position of the symbol, including the load slot. Two instances, one with each fill mode, receive the same stimulus. Their line outputs are decoded back to symbols in the bench.

// File: rtl/enc45_pkg.sv
package enc45_pkg;
   localparam int NIB_W = 4;
   localparam int SYM_W = 5;
   localparam logic [SYM_W-1:0] ESC_SYM  = 5'b00010;
   localparam logic [SYM_W-1:0] HOLD_SYM = 5'b00000;

   typedef logic [NIB_W-1:0] nib_t;
   typedef logic [SYM_W-1:0] sym_t;

   // 16-entry data code map, listed by nibble value
   function automatic sym_t data_code(input nib_t n);
      sym_t s;
      case (n)
         4'h0: s = 5'b10101;
         4'h1: s = 5'b01001;
         4'h2: s = 5'b01010;
         4'h3: s = 5'b01011;
         4'h4: s = 5'b00111;
         4'h5: s = 5'b01101;
         4'h6: s = 5'b01110;
         4'h7: s = 5'b01111;
         4'h8: s = 5'b10010;
         4'h9: s = 5'b11001;
         4'hA: s = 5'b11010;
         4'hB: s = 5'b11011;
         4'hC: s = 5'b10111;
         4'hD: s = 5'b11101;
         4'hE: s = 5'b11110;
         default: s = 5'b11111;
      endcase
      return s;
   endfunction
endpackage

// File: rtl/enc45_symmap.sv
module enc45_symmap
   import enc45_pkg::*;
#(
   parameter int N_W = NIB_W,
   parameter int S_W = SYM_W
) (
   input  logic [N_W-1:0] nib_i,
   input  logic           esc_i,
   output logic [S_W-1:0] sym_o
);
   generate
      if (N_W != NIB_W || S_W != SYM_W) begin : g_bad_width
         $error("enc45_symmap: code map is defined for 4-bit nibbles and 5-bit symbols");
      end
   endgenerate

   always_comb begin
      if (esc_i) sym_o = ESC_SYM;
      else       sym_o = data_code(nib_i);
   end
endmodule

// File: rtl/enc45_shifter.sv
module enc45_shifter
   import enc45_pkg::*;
#(
   parameter int S_W       = SYM_W,
   parameter bit IDLE_HOLD = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           bit_en,
   input  logic           load_valid,
   input  logic [S_W-1:0] load_sym,
   output logic           load_take,
   output logic           bit_o
);
   localparam int CNT_W = $clog2(S_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(S_W - 1);

   generate
      if (S_W < 2) begin : g_bad_len
         $error("enc45_shifter: symbol must be at least two bits");
      end
   endgenerate

   logic [S_W-1:0]   sym_q;
   logic [CNT_W-1:0] cnt_q;
   logic [S_W-1:0]   fill_sym;

   generate
      if (IDLE_HOLD) begin : g_fill_hold
         assign fill_sym = S_W'(HOLD_SYM);
      end else begin : g_fill_esc
         assign fill_sym = S_W'(ESC_SYM);
      end
   endgenerate

   logic at_last;
   assign at_last   = (cnt_q == LAST);
   assign load_take = bit_en && at_last;
   assign bit_o     = sym_q[LAST - cnt_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sym_q <= '0;
         cnt_q <= LAST;
      end else if (bit_en) begin
         if (at_last) begin
            sym_q <= load_valid ? load_sym : fill_sym;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R1
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);
   // R6
   pause_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> ($stable(cnt_q) && $stable(sym_q)));
endmodule

// File: rtl/enc45_nrzi.sv
module enc45_nrzi (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic bit_i,
   output logic line_o
);
   logic line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      line_q <= 1'b0;
      else if (bit_en) line_q <= line_q ^ bit_i;
   end

   assign line_o = line_q;

   // R4
   one_toggles_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && bit_i) |=> (line_q != $past(line_q)));
   // R6
   idle_line_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(line_q));
endmodule

// File: rtl/line_enc45.sv
module line_enc45
   import enc45_pkg::*;
#(
   parameter bit IDLE_HOLD = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [NIB_W-1:0] in_nib,
   input  logic             in_esc,
   output logic             line_o
);
   logic [SYM_W-1:0] mapped_sym;
   logic             ser_bit;

   enc45_symmap #(.N_W(NIB_W), .S_W(SYM_W)) u_map (
      .nib_i (in_nib),
      .esc_i (in_esc),
      .sym_o (mapped_sym)
   );

   enc45_shifter #(.S_W(SYM_W), .IDLE_HOLD(IDLE_HOLD)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_en     (bit_en),
      .load_valid (in_valid),
      .load_sym   (mapped_sym),
      .load_take  (in_ready),
      .bit_o      (ser_bit)
   );

   enc45_nrzi u_nrzi (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_en (bit_en),
      .bit_i  (ser_bit),
      .line_o (line_o)
   );

   // R5
   ready_needs_bit_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> bit_en);
   // R3
   esc_first_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_esc) |=> (ser_bit == 1'b0));
endmodule

// File: tb/line_enc45_tb.sv
module line_enc45_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_esc = 1'b0;
   logic [3:0] in_nib = 4'h0;
   logic       rdy_a, rdy_b, line_a, line_b;

   int vectors = 0;
   int misses  = 0;

   line_enc45 #(.IDLE_HOLD(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_valid(in_valid),
      .in_ready(rdy_a), .in_nib(in_nib), .in_esc(in_esc), .line_o(line_a));

   line_enc45 #(.IDLE_HOLD(1'b1)) u_hold (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_valid(in_valid),
      .in_ready(rdy_b), .in_nib(in_nib), .in_esc(in_esc), .line_o(line_b));

   always #5 clk = ~clk;

   function automatic logic [4:0] spec_sym(input logic esc, input logic [3:0] n);
      if (esc) return 5'b00010;
      case (n)
         4'h0: return 5'b10101;  4'h1: return 5'b01001;
         4'h2: return 5'b01010;  4'h3: return 5'b01011;
         4'h4: return 5'b00111;  4'h5: return 5'b01101;
         4'h6: return 5'b01110;  4'h7: return 5'b01111;
         4'h8: return 5'b10010;  4'h9: return 5'b11001;
         4'hA: return 5'b11010;  4'hB: return 5'b11011;
         4'hC: return 5'b10111;  4'hD: return 5'b11101;
         4'hE: return 5'b11110;  default: return 5'b11111;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         misses++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   initial begin
      #(10 * 150000);
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      int ptr = 0;
      int phase = 4;
      bit first = 1'b1;
      logic [4:0] rx_a = '0, rx_b = '0;
      logic [4:0] exp_a = '0, exp_b = '0;
      string tag_a = "R2", tag_b = "R2";
      logic prev_a, prev_b;
      logic be, vld, esc;
      logic [3:0] nib;
      int code;

      repeat (3) @(negedge clk);
      // R7: reset level
      check(line_a == 1'b0, "R7 reset line", line_a, 0);
      check(line_b == 1'b0, "R7 reset line hold-mode", line_b, 0);
      rst_n = 1'b1;

      for (int i = 0; i < 1200; i++) begin
         @(negedge clk);
         if (i < 200)       begin be = 1'b1;          vld = 1'b1; end
         else if (i < 700)  begin be = (i % 3 != 0);  vld = (i % 11 >= 2); end
         else if (i < 800)  begin be = 1'b1;          vld = 1'b0; end
         else               begin be = (i % 7 != 3);  vld = 1'b1; end
         code = ptr % 17;
         esc  = (code == 16);
         nib  = esc ? 4'((ptr * 5) % 16) : 4'(code);
         bit_en = be; in_valid = vld; in_esc = esc; in_nib = nib;
         #1;
         // R5 (and R7 for the first slot): ready only on a load slot
         check(rdy_a == (be && phase == 4), "R5 ready", rdy_a, be && phase == 4);
         check(rdy_b == (be && phase == 4), "R5 ready hold-mode", rdy_b, be && phase == 4);
         prev_a = line_a; prev_b = line_b;
         @(posedge clk);
         #2;
         if (!be) begin
            // R6: no bit slot, no line change
            check(line_a == prev_a, "R6 line held", line_a, prev_a);
            check(line_b == prev_b, "R6 line held hold-mode", line_b, prev_b);
         end else begin
            // R4: NRZI decode, R1: MSB-first shift into the receive register
            rx_a = {rx_a[3:0], line_a ^ prev_a};
            rx_b = {rx_b[3:0], line_b ^ prev_b};
            if (phase == 4) begin
               if (first) begin
                  check(line_a == 1'b0, "R7 first slot zero", line_a, 0);
                  check(line_b == 1'b0, "R7 first slot zero hold-mode", line_b, 0);
               end else begin
                  check(rx_a == exp_a, {tag_a, " symbol (R1 R4)"}, rx_a, exp_a);
                  check(rx_b == exp_b, {tag_b, " symbol hold-mode (R1 R4)"}, rx_b, exp_b);
               end
               first = 1'b0;
               if (vld) begin
                  exp_a = spec_sym(esc, nib); exp_b = exp_a;
                  tag_a = esc ? "R3" : "R2"; tag_b = tag_a;
                  ptr++;
               end else begin
                  exp_a = 5'b00010; tag_a = "R8";
                  exp_b = 5'b00000; tag_b = "R9";
               end
               phase = 0;
            end else begin
               phase++;
            end
         end
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule